// File: doc/BRIEF.md
# DS3 Far-End Receive Failure Monitor

This block watches the overhead of every received DS3 M-frame after an upstream aligner has found the frame. On each frame-boundary strobe it looks at the two X bits of the frame. If both are zero, the far end is reporting a receive failure. The block tracks this remote-defect condition and updates its decision only while the aligner reports valid alignment. A parameter sets how many consecutive frames must disagree with the current decision before the decision flips, so a single corrupted X bit cannot toggle the state.

The defect state is shown in a read-only status register. Every change of state, whether declaration or clearing, latches a change flag in an interrupt status register. That register clears itself when it is read. An active-low interrupt pin stays low while any latched flag is also enabled in a writable enable register. Register access uses a simple port: a read strobe with registered data one cycle later, and a write strobe.

Top module: `ferf_monitor`

## Requirements
- R1: After reset, the defect state is 0, all three registers read 0 and `irq_n` is 1.
- R2: The defect is declared after CONFIRM_FRAMES consecutive qualified frames in which both X bits are 0. A qualified frame is a cycle with `frm_strobe` and `frm_aligned` both high. The default CONFIRM_FRAMES is 2.
- R3: The defect is cleared after CONFIRM_FRAMES consecutive qualified frames in which at least one X bit is 1.
- R4: A qualified frame that agrees with the current decision restarts the run of disagreeing frames from zero.
- R5: A strobe with `frm_aligned` low, and any cycle without a strobe, leaves both the decision and the run count unchanged.
- R6: A read of address 0x1 returns the defect state in bit 4, with all other bits 0.
- R7: Every change of the defect state, in either direction, sets bit 3 of the interrupt status register at address 0x3. That bit is the only implemented bit, and all other bits read 0.
- R8: A read of address 0x3 returns its current value and then clears it to 0. If a change of state happens in the same cycle as the read, bit 3 stays set.
- R9: `irq_n` is 0 exactly while the interrupt status register ANDed with the enable register is nonzero.
- R10: The enable register at address 0x2 is writable and keeps only bit 3. Writes to address 0x1 or 0x3 have no effect.
- R11: Read data appears on `rd_data` in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_strobe | input | 1 | One-cycle pulse at each M-frame boundary |
| frm_aligned | input | 1 | Frame alignment valid |
| xbit_1 | input | 1 | First X bit of the frame just ended |
| xbit_2 | input | 1 | Second X bit of the frame just ended |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | REG_W | Registered read data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | REG_W | Write data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions assume that `frm_strobe` is a single-cycle pulse. They also assume that the X bits are stable during the strobe cycle, and that a read of the interrupt register is a single `rd_en` cycle. The bench drives every frame as a one-cycle strobe set at a falling edge and removed at the next falling edge. It issues each read and write the same way, so these conditions always hold. Streak counting, unaligned strobes and a read that collides with a change are all exercised through these same one-cycle pulses.

// File: rtl/ferf_pkg.sv
package ferf_pkg;
  localparam int REG_W      = 8;
  localparam int ADR_STATUS = 1;
  localparam int ADR_IEN    = 2;
  localparam int ADR_ISTAT  = 3;
  localparam int DEFECT_BIT = 4;
  localparam int CHG_BIT    = 3;

  // both X bits zero means the far end reports a receive failure
  function automatic logic frame_fails(input logic xa, input logic xb);
    return !xa && !xb;
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic defect);
    logic [REG_W-1:0] w;
    w = '0;
    w[DEFECT_BIT] = defect;
    return w;
  endfunction

  function automatic logic [REG_W-1:0] chg_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[CHG_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ferf_detect.sv
module ferf_detect #(
  parameter int CONFIRM_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frm_strobe,
  input  logic frm_aligned,
  input  logic xbit_1,
  input  logic xbit_2,
  output logic defect,
  output logic flip
);
  import ferf_pkg::*;
  localparam int CW = $clog2(CONFIRM_FRAMES + 1);

  logic [CW-1:0] run_q;
  logic qual, disagree, at_limit;

  assign qual     = frm_strobe && frm_aligned;
  assign disagree = frame_fails(xbit_1, xbit_2) != defect;
  assign at_limit = run_q == CW'(CONFIRM_FRAMES - 1);
  assign flip     = qual && disagree && at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      defect <= 1'b0;
    end else if (qual) begin
      if (!disagree || at_limit) run_q <= '0;
      else                      run_q <= run_q + 1'b1;
      if (flip) defect <= !defect;
    end
  end

  // R5
  defect_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(defect) |-> $past(frm_strobe && frm_aligned));
  // R4
  run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < CW'(CONFIRM_FRAMES));
  // R5
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frm_strobe && frm_aligned) |=> $stable(run_q));
endmodule

// File: rtl/ferf_irq.sv
module ferf_irq (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flip,
  input  logic                      istat_rd,
  input  logic                      ien_we,
  input  logic [ferf_pkg::REG_W-1:0] ien_wd,
  output logic [ferf_pkg::REG_W-1:0] istat_q,
  output logic [ferf_pkg::REG_W-1:0] ien_q,
  output logic                      irq_n
);
  import ferf_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      istat_q <= '0;
      ien_q   <= '0;
    end else begin
      if (flip)          istat_q <= chg_mask();
      else if (istat_rd) istat_q <= '0;
      if (ien_we) ien_q <= ien_wd & chg_mask();
    end
  end

  assign irq_n = ~|(istat_q & ien_q);

  // R7
  set_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> istat_q[CHG_BIT]);
  // R8
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_rd && !flip) |=> istat_q == '0);
  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_q[CHG_BIT] && !istat_rd) |=> istat_q[CHG_BIT]);
endmodule

// File: rtl/ferf_regs.sv
module ferf_regs #(
  parameter int ADDR_W = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [ferf_pkg::REG_W-1:0] wr_data,
  input  logic                      defect,
  input  logic [ferf_pkg::REG_W-1:0] istat_q,
  input  logic [ferf_pkg::REG_W-1:0] ien_q,
  output logic                      istat_rd,
  output logic                      ien_we,
  output logic [ferf_pkg::REG_W-1:0] ien_wd,
  output logic [ferf_pkg::REG_W-1:0] rd_data
);
  import ferf_pkg::*;
  logic [REG_W-1:0] mux;

  assign istat_rd = rd_en && rd_addr == ADDR_W'(ADR_ISTAT);
  assign ien_we   = wr_en && wr_addr == ADDR_W'(ADR_IEN);
  assign ien_wd   = wr_data;

  always_comb begin
    mux = '0;
    if (rd_addr == ADDR_W'(ADR_STATUS))     mux = status_word(defect);
    else if (rd_addr == ADDR_W'(ADR_IEN))   mux = ien_q;
    else if (rd_addr == ADDR_W'(ADR_ISTAT)) mux = istat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mux;
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/ferf_monitor.sv
module ferf_monitor #(
  parameter int ADDR_W         = 4,
  parameter int CONFIRM_FRAMES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frm_strobe,
  input  logic                      frm_aligned,
  input  logic                      xbit_1,
  input  logic                      xbit_2,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [ferf_pkg::REG_W-1:0] rd_data,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [ferf_pkg::REG_W-1:0] wr_data,
  output logic                      irq_n
);
  import ferf_pkg::*;

  logic defect, flip, istat_rd, ien_we;
  logic [REG_W-1:0] istat_q, ien_q, ien_wd;

  ferf_detect #(.CONFIRM_FRAMES(CONFIRM_FRAMES)) u_det (
    .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .frm_aligned(frm_aligned),
    .xbit_1(xbit_1), .xbit_2(xbit_2), .defect(defect), .flip(flip));

  ferf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .flip(flip), .istat_rd(istat_rd),
    .ien_we(ien_we), .ien_wd(ien_wd), .istat_q(istat_q), .ien_q(ien_q),
    .irq_n(irq_n));

  ferf_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .defect(defect),
    .istat_q(istat_q), .ien_q(ien_q), .istat_rd(istat_rd), .ien_we(ien_we),
    .ien_wd(ien_wd), .rd_data(rd_data));

  // R6
  status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == ADDR_W'(ADR_STATUS)) |=> rd_data == status_word($past(defect)));
  // R9
  pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && ien_q[CHG_BIT] && !ien_we) |=> !irq_n);
  // R2
  declare_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(defect) |-> $past(frame_fails(xbit_1, xbit_2)));
  // R3
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(defect) |-> $past(!frame_fails(xbit_1, xbit_2)));
endmodule

// File: tb/sim_ferf_monitor.sv
`timescale 1ns/1ps
module sim_ferf_monitor;
  logic clk = 0, rst_n = 0;
  logic frm_strobe = 0, frm_aligned = 0, xbit_1 = 0, xbit_2 = 0;
  logic rd_en = 0, wr_en = 0;
  logic [3:0] rd_addr = 0, wr_addr = 0;
  logic [7:0] wr_data = 0, rd_data, rv;
  logic irq_n;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  ferf_monitor u0 (.clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe),
    .frm_aligned(frm_aligned), .xbit_1(xbit_1), .xbit_2(xbit_2), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_n(irq_n));

  // {aligned, x1, x2, expected defect, expected change}; confirm run of 2
  localparam logic [4:0] VEC [13] = '{
    5'b1_00_0_0, 5'b1_00_1_1, 5'b1_00_1_0, 5'b1_10_1_0, 5'b1_00_1_0,
    5'b1_01_1_0, 5'b0_11_1_0, 5'b1_11_0_1, 5'b1_00_0_0, 5'b0_00_0_0,
    5'b1_10_0_0, 5'b1_00_0_0, 5'b1_00_1_1 };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic al, input logic a, input logic b);
    @(negedge clk);
    frm_strobe = 1; frm_aligned = al; xbit_1 = a; xbit_2 = b;
    @(negedge clk);
    frm_strobe = 0;
  endtask

  task automatic rd(input logic [3:0] ad, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1; rd_addr = ad;
    @(negedge clk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic wr(input logic [3:0] ad, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  initial begin
    #3_000_000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq_n", {7'd0, irq_n}, 8'd1);
    rd(4'h1, rv); check("R1 status", rv, 8'h00);
    rd(4'h2, rv); check("R1 enable", rv, 8'h00);
    rd(4'h3, rv); check("R1 istat", rv, 8'h00);
    // R10 enable keeps bit 3 only
    wr(4'h2, 8'hFF);
    rd(4'h2, rv); check("R10 enable mask", rv, 8'h08);
    for (int i = 0; i < 13; i++) begin
      frame(VEC[i][4], VEC[i][3], VEC[i][2]);
      // R9 pin low only after a change
      check($sformatf("R9 irq_n v%0d", i), {7'd0, irq_n}, {7'd0, !VEC[i][0]});
      // R7 R8 change flag read then cleared
      rd(4'h3, rv); check($sformatf("R7 istat v%0d", i), rv, {4'd0, VEC[i][0], 3'd0});
      // R2 R3 R4 R5 R6 decision through status register
      rd(4'h1, rv); check($sformatf("R6 status v%0d", i), rv, {3'd0, VEC[i][1], 4'd0});
      check($sformatf("R8 irq_n cleared v%0d", i), {7'd0, irq_n}, 8'd1);
    end
    // R5 X bits toggling with no strobe
    @(negedge clk); xbit_1 = 1; xbit_2 = 1; repeat (4) @(negedge clk);
    rd(4'h1, rv); check("R5 no strobe", rv, 8'h10);
    // R10 writes to status and istat ignored
    wr(4'h1, 8'h00); rd(4'h1, rv); check("R10 status write", rv, 8'h10);
    wr(4'h3, 8'hFF); rd(4'h3, rv); check("R10 istat write", rv, 8'h00);
    check("R10 irq_n after istat write", {7'd0, irq_n}, 8'd1);
    // R8 change coinciding with read keeps flag
    frame(1, 1, 1);
    @(negedge clk);
    frm_strobe = 1; frm_aligned = 1; xbit_1 = 1; xbit_2 = 0;
    rd_en = 1; rd_addr = 4'h3;
    @(negedge clk);
    frm_strobe = 0; rd_en = 0;
    check("R11 read before change", rd_data, 8'h00);
    rd(4'h3, rv); check("R8 set wins over clear", rv, 8'h08);
    rd(4'h1, rv); check("R3 cleared", rv, 8'h00);
    // R9 masked: change with enable off leaves pin high
    wr(4'h2, 8'h00);
    frame(1, 0, 0); frame(1, 0, 0);
    check("R9 masked irq_n", {7'd0, irq_n}, 8'd1);
    wr(4'h2, 8'h08);
    check("R9 unmask irq_n", {7'd0, irq_n}, 8'd0);
    rd(4'h3, rv); check("R2 declared flag", rv, 8'h08);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule